// File: doc/BRIEF.md
# Ethernet Receive Frame Filter

This block sits behind the physical-layer receiver and watches a byte stream that carries a per-byte valid strobe plus start and end markers. It skips the preamble up to the start-of-frame delimiter and parses the header that follows. Frames addressed to the configured station address that carry one of the two supported EtherTypes (address resolution or IPv4) have their payload passed on.

A CRC-32 runs over every byte from the first destination-address byte through the last check-sequence byte. At the end of the frame the block either announces the frame with a single-cycle pulse and a type bit, or reports a checksum failure with a single-cycle error pulse. Downstream network-layer logic uses the pulse and the type bit to decide how to treat the payload bytes it has already collected.

Top module: `eth_rx_filter`

## Requirements
- R1: While reset is asserted and on the first cycle after it is released, `frm_new`, `frm_crc_err` and `pl_valid` are low.
- R2: Bytes are skipped until one equal to 0xD5 arrives. Header offset 0 is the byte after it, and any number of preamble bytes may come before it.
- R3: Header offsets 0..5 must equal the station address `STATION_MAC`, with offset 0 compared against bits 47:40. A frame with any mismatch produces neither `frm_new` nor payload.
- R4: Offsets 12 and 13 form the EtherType, high byte first. 0x0806 gives type 0, 0x0800 gives type 1, and any other value drops the frame.
- R5: For a frame that passes R3 and R4 and has a good CRC, `frm_new` is high for exactly one cycle, on the cycle after the byte that carries `rx_eof`. `frm_is_ipv4` holds the type while `frm_new` is high.
- R6: The CRC covers offsets 0 through the end-of-frame byte. Each byte is bit-reversed and then shifted in MSB-first with polynomial 0x04C11DB7 from an all-ones start. The frame is good when the register reads 0xC704DD7B after its last byte. That is the result for a frame whose 4-byte check sequence is the standard Ethernet FCS sent least-significant byte first.
- R7: A frame that has passed its 0xD5 byte and ends with a bad CRC pulses `frm_crc_err` for one cycle, on the cycle after its end-of-frame byte. This happens whether or not its address matched, and `frm_new` is never raised for it.
- R8: For a frame that passes R3 and R4, every byte from offset 14 through the end-of-frame byte appears on `pl_data`, with `pl_valid` high, one cycle after it is received. The check-sequence bytes are included.
- R9: Cycles with `rx_valid` low have no effect, whatever `rx_data`, `rx_sof` and `rx_eof` hold.
- R10: A byte flagged with `rx_sof` abandons any frame in progress and restarts the preamble search on that byte. The abandoned frame produces no pulse of either kind.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| rx_valid | input | 1 | Byte strobe for `rx_data` |
| rx_data | input | 8 | Received byte |
| rx_sof | input | 1 | First byte of a frame (start of preamble) |
| rx_eof | input | 1 | Last byte of a frame (last FCS byte) |
| frm_new | output | 1 | One-cycle accept pulse |
| frm_is_ipv4 | output | 1 | Frame type, 0 = ARP, 1 = IPv4, valid with `frm_new` |
| frm_crc_err | output | 1 | One-cycle CRC failure pulse |
| pl_valid | output | 1 | Payload byte strobe |
| pl_data | output | 8 | Forwarded payload byte |

## Verification
Every result is registered once. A payload byte, an accept pulse or an error pulse is due on the rising edge after the clock edge that samples the byte causing it, and an idle cycle is due to leave all strobes low. The bench's model pushes one expected output set for each cycle it drives. It pops and compares that set 1 ns after the next rising edge. Timing is therefore checked to the exact cycle, as well as the values. Idle cycles carry deliberately misleading data and markers so that the effect of the valid strobe is checked too.

// File: rtl/eth_rxf_pkg.sv
package eth_rxf_pkg;
  localparam int unsigned BYTE_W    = 8;
  localparam int unsigned CRC_W     = 32;
  localparam int unsigned MAC_BYTES = 6;
  localparam int unsigned HDR_BYTES = 14;

  localparam logic [BYTE_W-1:0] SFD_BYTE    = 8'hD5;
  localparam logic [15:0]       ET_ARP      = 16'h0806;
  localparam logic [15:0]       ET_IPV4     = 16'h0800;
  localparam logic [CRC_W-1:0]  CRC_POLY    = 32'h04C1_1DB7;
  localparam logic [CRC_W-1:0]  CRC_INIT    = 32'hFFFF_FFFF;
  localparam logic [CRC_W-1:0]  CRC_RESIDUE = 32'hC704_DD7B;

  typedef enum logic [1:0] {ST_IDLE, ST_PRE, ST_HDR, ST_BODY} rx_state_e;

  // Advance an MSB-first CRC register by one byte, bit 7 of d first.
  function automatic logic [CRC_W-1:0] crc_step_byte(input logic [CRC_W-1:0] c,
                                                     input logic [BYTE_W-1:0] d);
    logic [CRC_W-1:0] r;
    r = c;
    for (int i = BYTE_W - 1; i >= 0; i--) begin
      if (r[CRC_W-1] ^ d[i]) r = (r << 1) ^ CRC_POLY;
      else                   r = r << 1;
    end
    return r;
  endfunction
endpackage

// File: rtl/eth_rxf_crc.sv
module eth_rxf_crc
  import eth_rxf_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              restart,
  input  logic              byte_en,
  input  logic [BYTE_W-1:0] din,
  output logic [CRC_W-1:0]  crc_nxt
);
  logic [BYTE_W-1:0] din_rev;
  logic [CRC_W-1:0]  crc_q;

  for (genvar b = 0; b < BYTE_W; b++) begin : g_rev
    assign din_rev[b] = din[BYTE_W-1-b];
  end

  always_comb crc_nxt = crc_step_byte(crc_q, din_rev);

  always_ff @(posedge clk) begin
    if (rst)          crc_q <= CRC_INIT;
    else if (restart) crc_q <= CRC_INIT;
    else if (byte_en) crc_q <= crc_nxt;
  end

  // R6
  crc_restart_chk: assert property (@(posedge clk) disable iff (rst)
    restart |=> (crc_q == CRC_INIT));
endmodule

// File: rtl/eth_rxf_parser.sv
module eth_rxf_parser
  import eth_rxf_pkg::*;
#(
  parameter logic [8*MAC_BYTES-1:0] STATION_MAC = 48'h02_00_00_AB_CD_EF
)(
  input  logic              clk,
  input  logic              rst,
  input  logic              in_valid,
  input  logic [BYTE_W-1:0] in_byte,
  input  logic              in_sof,
  input  logic              in_eof,
  output logic              crc_restart,
  output logic              crc_feed,
  output logic              body_byte,
  output logic              frame_end,
  output logic              end_in_body,
  output logic              hdr_ok,
  output logic              is_ipv4
);
  localparam int unsigned CNT_W = $clog2(HDR_BYTES + 1);
  localparam logic [CNT_W-1:0] CNT_MAC  = CNT_W'(MAC_BYTES);
  localparam logic [CNT_W-1:0] CNT_ETH  = CNT_W'(HDR_BYTES - 2);
  localparam logic [CNT_W-1:0] CNT_ETL  = CNT_W'(HDR_BYTES - 1);
  localparam logic [CNT_W-1:0] CNT_BODY = CNT_W'(HDR_BYTES);

  rx_state_e         st, st_eff;
  logic [CNT_W-1:0]  cnt;
  logic              mac_ok, type_known, type_ip;
  logic [BYTE_W-1:0] type_hi, exp_mac;
  logic [15:0]       ethertype;

  assign st_eff    = (in_valid && in_sof) ? ST_PRE : st;
  assign ethertype = {type_hi, in_byte};

  always_comb begin
    exp_mac = '0;
    for (int k = 0; k < MAC_BYTES; k++)
      if (cnt == CNT_W'(k)) exp_mac = STATION_MAC[8*(MAC_BYTES-1-k) +: 8];
  end

  assign crc_restart = in_valid && (st_eff == ST_PRE) && (in_byte == SFD_BYTE);
  assign crc_feed    = in_valid && ((st_eff == ST_HDR) || (st_eff == ST_BODY));
  assign body_byte   = in_valid && (st_eff == ST_BODY);
  assign frame_end   = crc_feed && in_eof;
  assign end_in_body = body_byte && in_eof;
  assign hdr_ok      = mac_ok && type_known;
  assign is_ipv4     = type_ip;

  always_ff @(posedge clk) begin
    if (rst) begin
      st         <= ST_IDLE;
      cnt        <= '0;
      mac_ok     <= 1'b0;
      type_known <= 1'b0;
      type_ip    <= 1'b0;
      type_hi    <= '0;
    end else if (in_valid) begin
      case (st_eff)
        ST_PRE: begin
          if (in_eof) st <= ST_IDLE;
          else if (in_byte == SFD_BYTE) begin
            st         <= ST_HDR;
            cnt        <= '0;
            mac_ok     <= 1'b1;
            type_known <= 1'b0;
            type_ip    <= 1'b0;
          end else st <= ST_PRE;
        end
        ST_HDR: begin
          if ((cnt < CNT_MAC) && (in_byte != exp_mac)) mac_ok <= 1'b0;
          if (cnt == CNT_ETH) type_hi <= in_byte;
          if (cnt == CNT_ETL) begin
            type_known <= (ethertype == ET_ARP) || (ethertype == ET_IPV4);
            type_ip    <= (ethertype == ET_IPV4);
          end
          cnt <= cnt + 1'b1;
          if (in_eof)               st <= ST_IDLE;
          else if (cnt == CNT_ETL)  st <= ST_BODY;
        end
        ST_BODY: if (in_eof) st <= ST_IDLE;
        default: ;
      endcase
    end
  end

  // R2
  body_offset_chk: assert property (@(posedge clk) disable iff (rst)
    (st == ST_BODY) |-> (cnt == CNT_BODY));
endmodule

// File: rtl/eth_rx_filter.sv
module eth_rx_filter
  import eth_rxf_pkg::*;
#(
  parameter logic [8*MAC_BYTES-1:0] STATION_MAC = 48'h02_00_00_AB_CD_EF
)(
  input  logic              clk,
  input  logic              rst,
  input  logic              rx_valid,
  input  logic [BYTE_W-1:0] rx_data,
  input  logic              rx_sof,
  input  logic              rx_eof,
  output logic              frm_new,
  output logic              frm_is_ipv4,
  output logic              frm_crc_err,
  output logic              pl_valid,
  output logic [BYTE_W-1:0] pl_data
);
  logic             crc_restart, crc_feed, body_byte, frame_end, end_in_body;
  logic             hdr_ok, is_ipv4, crc_good, accept;
  logic [CRC_W-1:0] crc_nxt;

  eth_rxf_parser #(.STATION_MAC(STATION_MAC)) u_parser (
    .clk(clk), .rst(rst), .in_valid(rx_valid), .in_byte(rx_data),
    .in_sof(rx_sof), .in_eof(rx_eof), .crc_restart(crc_restart),
    .crc_feed(crc_feed), .body_byte(body_byte), .frame_end(frame_end),
    .end_in_body(end_in_body), .hdr_ok(hdr_ok), .is_ipv4(is_ipv4)
  );

  eth_rxf_crc u_crc (
    .clk(clk), .rst(rst), .restart(crc_restart), .byte_en(crc_feed),
    .din(rx_data), .crc_nxt(crc_nxt)
  );

  assign crc_good = (crc_nxt == CRC_RESIDUE);
  assign accept   = end_in_body && hdr_ok && crc_good;

  always_ff @(posedge clk) begin
    if (rst) begin
      frm_new     <= 1'b0;
      frm_is_ipv4 <= 1'b0;
      frm_crc_err <= 1'b0;
      pl_valid    <= 1'b0;
      pl_data     <= '0;
    end else begin
      frm_new     <= accept;
      frm_crc_err <= frame_end && !crc_good;
      pl_valid    <= body_byte && hdr_ok;
      if (accept)             frm_is_ipv4 <= is_ipv4;
      if (body_byte && hdr_ok) pl_data    <= rx_data;
    end
  end

  // R7
  new_err_excl_chk: assert property (@(posedge clk) disable iff (rst)
    !(frm_new && frm_crc_err));
  // R5
  new_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    frm_new |=> !frm_new);
  // R5
  new_after_eof_chk: assert property (@(posedge clk) disable iff (rst)
    frm_new |-> $past(rx_valid && rx_eof));
  // R8
  pl_after_valid_chk: assert property (@(posedge clk) disable iff (rst)
    pl_valid |-> $past(rx_valid));
endmodule

// File: tb/eth_rx_filter_bench.sv
`timescale 1ns/1ps
module eth_rx_filter_bench;
  localparam logic [47:0] DEV = 48'h02_00_00_AB_CD_EF;

  typedef struct packed {
    logic       nf;
    logic       ty;
    logic       err;
    logic       pv;
    logic [7:0] pb;
  } exp_t;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       rx_valid = 1'b0, rx_sof = 1'b0, rx_eof = 1'b0;
  logic [7:0] rx_data = 8'h00;
  logic       frm_new, frm_is_ipv4, frm_crc_err, pl_valid;
  logic [7:0] pl_data;

  exp_t  exp_q[$];
  string tag_q[$];
  int    n_checks = 0, n_fail = 0;
  bit    mon_en = 1'b0, done = 1'b0;

  always #2.5 clk = ~clk;

  eth_rx_filter #(.STATION_MAC(DEV)) u_eth_rx_filter (
    .clk(clk), .rst(rst), .rx_valid(rx_valid), .rx_data(rx_data),
    .rx_sof(rx_sof), .rx_eof(rx_eof), .frm_new(frm_new),
    .frm_is_ipv4(frm_is_ipv4), .frm_crc_err(frm_crc_err),
    .pl_valid(pl_valid), .pl_data(pl_data)
  );

  // Standard reflected Ethernet CRC, as a transmitter would compute it.
  function automatic logic [31:0] fcs_of(input logic [7:0] q[$]);
    logic [31:0] c = 32'hFFFF_FFFF;
    foreach (q[i]) begin
      c ^= {24'h0, q[i]};
      for (int k = 0; k < 8; k++) c = c[0] ? ((c >> 1) ^ 32'hEDB8_8320) : (c >> 1);
    end
    return ~c;
  endfunction

  task automatic drive_byte(input logic [7:0] b, input bit sof, input bit eof,
                            input exp_t e, input string tag);
    @(negedge clk);
    rx_valid = 1'b1; rx_data = b; rx_sof = sof; rx_eof = eof;
    exp_q.push_back(e); tag_q.push_back(tag);
  endtask

  // R9: idle cycles carry a delimiter value and both markers.
  task automatic drive_idle(input string tag);
    @(negedge clk);
    rx_valid = 1'b0; rx_data = 8'hD5; rx_sof = 1'b1; rx_eof = 1'b1;
    exp_q.push_back('0); tag_q.push_back(tag);
  endtask

  task automatic send_frame(input logic [47:0] dst, input logic [15:0] et,
                            input int plen, input int npre, input bit bad,
                            input int gap, input int cut, input string tag);
    logic [7:0]  q[$];
    logic [31:0] fcs;
    int          total, nsend, o;
    bit          good, ip, last;
    logic [7:0]  b;
    exp_t        e;
    for (int k = 0; k < 6; k++) q.push_back(dst[8*(5-k) +: 8]);
    for (int k = 0; k < 6; k++) q.push_back(8'h10 + 8'(k));
    q.push_back(et[15:8]); q.push_back(et[7:0]);
    for (int k = 0; k < plen; k++) q.push_back(8'(k * 7 + 3));
    fcs = fcs_of(q);
    if (bad) fcs ^= 32'h0000_0100;
    for (int k = 0; k < 4; k++) q.push_back(fcs[8*k +: 8]);
    total = npre + 1 + q.size();
    nsend = (cut >= 0) ? cut : total;
    good  = (dst == DEV) && ((et == 16'h0806) || (et == 16'h0800));
    ip    = (et == 16'h0800);
    for (int i = 0; i < nsend; i++) begin
      b    = (i < npre) ? 8'h55 : (i == npre) ? 8'hD5 : q[i-npre-1];
      o    = i - npre - 1;
      last = (cut < 0) && (i == total - 1);
      e.pv  = good && (o >= 14);
      e.pb  = b;
      e.nf  = last && good && !bad;
      e.ty  = last && good && !bad && ip;
      e.err = last && bad;
      drive_byte(b, i == 0, last, e, tag);
      if (gap > 0 && (i % gap) == gap - 1 && i != nsend - 1) drive_idle(tag);
    end
    drive_idle(tag);
    drive_idle(tag);
  endtask

  // Reference comparison, one entry per driven cycle.
  initial begin
    exp_t  e;
    string t;
    forever begin
      @(posedge clk);
      #1;
      if (mon_en) begin
        if (exp_q.size() > 0) begin e = exp_q.pop_front(); t = tag_q.pop_front(); end
        else begin e = '0; t = "idle"; end
        n_checks++;
        if (frm_new !== e.nf || frm_crc_err !== e.err || pl_valid !== e.pv ||
            (e.pv && pl_data !== e.pb) || (e.nf && frm_is_ipv4 !== e.ty)) begin
          n_fail++;
          $display("FAIL [%s] R5/R7/R8: new=%0b err=%0b type=%0b pv=%0b pd=%02h expected new=%0b err=%0b type=%0b pv=%0b pd=%02h",
                   t, frm_new, frm_crc_err, frm_is_ipv4, pl_valid, pl_data,
                   e.nf, e.err, e.ty, e.pv, e.pb);
        end
      end
    end
  end

  initial begin
    repeat (5) @(negedge clk);
    // R1: outputs low during reset
    n_checks++;
    if (frm_new || frm_crc_err || pl_valid) begin
      n_fail++;
      $display("FAIL R1: new=%0b err=%0b pv=%0b expected 0 0 0", frm_new, frm_crc_err, pl_valid);
    end
    rst = 1'b0;
    mon_en = 1'b1;
    drive_idle("R1 after reset");
    send_frame(DEV, 16'h0806, 28, 7, 0, 0, -1, "R4 R5 R6 ARP good");
    send_frame(DEV, 16'h0800, 40, 7, 0, 3, -1, "R4 R8 R9 IPv4 with gaps");
    send_frame(48'h02_00_00_AB_CD_EE, 16'h0800, 20, 7, 0, 0, -1, "R3 last address byte differs");
    send_frame(48'h03_00_00_AB_CD_EF, 16'h0806, 20, 7, 0, 0, -1, "R3 first address byte differs");
    send_frame(DEV, 16'h86DD, 20, 7, 0, 0, -1, "R4 unknown EtherType");
    send_frame(DEV, 16'h0800, 30, 7, 1, 0, -1, "R7 bad CRC accepted header");
    send_frame(48'hFF_FF_FF_FF_FF_FF, 16'h0800, 20, 7, 1, 0, -1, "R7 bad CRC dropped address");
    send_frame(DEV, 16'h0806, 28, 1, 0, 0, -1, "R2 short preamble");
    send_frame(DEV, 16'h0800, 26, 15, 0, 2, -1, "R2 R9 long preamble gaps");
    send_frame(DEV, 16'h0800, 20, 7, 0, 0, 12, "R10 abandoned frame");
    send_frame(DEV, 16'h0800, 22, 7, 0, 0, -1, "R10 frame after abandon");
    send_frame(DEV, 16'h0800, 0, 7, 0, 0, -1, "R8 R6 empty payload");
    repeat (4) @(negedge clk);
    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
    $finish;
  end

  initial begin
    repeat (50000) @(posedge clk);
    if (!done) begin
      n_checks++;
      n_fail++;
      $display("FAIL watchdog: run did not complete, expected completion");
      $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
      $finish;
    end
  end
endmodule